// File: doc/BRIEF.md
# Transmit CRC and End-of-Message Controller

This block holds the control state for the transmit side of one synchronous serial channel. It decodes a two-bit CRC command carried by host command writes and turns it into one-cycle initialisation requests for the receive CRC checker and the transmit CRC generator. It also keeps the end-of-message latch, which decides what happens when the transmitter runs out of data. When that latch is clear, an underrun closes the frame. The frame is closed with the CRC, or, in SDLC mode with the abort-on-underrun option, with an abort followed by flags. When the latch is set, an underrun asks only for idle fill.

The closing actions leave the block as a valid/ready stream of items. One underrun produces one short sequence of items, and the serializer takes them at its own pace. Once `close_valid` is high, the item on `close_kind` stays constant until a cycle in which `close_ready` is also high. The serializer may hold `close_ready` low for any number of cycles. While a sequence is still pending, further underruns are ignored.

A channel reset flushes any pending sequence and sets the latch. It deliberately leaves the transmit CRC generator alone. When the generator must be restarted for a new frame, the host sends the explicit command. Alternatively, the auto-reset option restarts it on the first byte loaded after a frame closes.

Top module: `tx_eom_ctrl`

## Requirements
- R1: A command write with code 2'b00 has no effect on any output or on the latch.
- R2: `rx_crc_init` pulses for one cycle, in the cycle after any of these: a command write with code 2'b01, a falling edge of `rx_enable`, or `rx_frame_end` while `sdlc_mode` is high.
- R3: A command write with code 2'b10 raises `tx_crc_init` for one cycle in the next cycle, but only if `tx_enable` is high at the write; otherwise it is ignored.
- R4: A command write with code 2'b11 clears `eom_latched` in the next cycle.
- R5: An accepted underrun with the latch clear, outside the SDLC-with-abort combination, presents one item of kind 1 (CRC) on the stream in the next cycle.
- R6: An accepted underrun with the latch clear, `sdlc_mode` high and `abort_on_underrun` high, presents one item of kind 2 (abort) followed by FLAGS_AFTER_ABORT items of kind 3 (flag).
- R7: In the cycle after the last item of a CRC or abort sequence is accepted, `eom_latched` is high and `eom_pulse` is high for exactly that one cycle.
- R8: An accepted underrun with the latch set presents one item of kind 0 (idle fill) and leaves `eom_latched` and `eom_pulse` unchanged.
- R9: `close_valid` and `close_kind` hold until `close_ready`. An underrun is accepted only while no item is pending and `tx_enable` is high; otherwise it is ignored.
- R10: `chan_reset` drops any pending item and sets `eom_latched` in the next cycle. It causes neither `tx_crc_init` nor `eom_pulse`.
- R11: With `auto_eom_reset` high, the first `data_load` seen with `tx_enable` high after reset or after a frame closes raises `tx_crc_init` in the next cycle. Later loads do not, until the next close.
- R12: After reset `eom_latched` is high, and all other outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 2 | CRC command code |
| chan_reset | input | 1 | Channel reset strobe |
| tx_enable | input | 1 | Transmitter enabled |
| rx_enable | input | 1 | Receiver enabled |
| sdlc_mode | input | 1 | SDLC framing selected |
| abort_on_underrun | input | 1 | Close SDLC frames with abort on underrun |
| auto_eom_reset | input | 1 | Restart the CRC generator automatically on the next frame |
| data_load | input | 1 | A data byte was loaded into the transmitter |
| rx_frame_end | input | 1 | Received frame ended |
| underrun | input | 1 | Transmit underrun strobe |
| close_ready | input | 1 | Serializer accepts the current item |
| close_valid | output | 1 | A closing item is pending |
| close_kind | output | 2 | Item kind: 0 idle, 1 CRC, 2 abort, 3 flag |
| tx_crc_init | output | 1 | Initialise the transmit CRC generator |
| rx_crc_init | output | 1 | Initialise the receive CRC checker |
| eom_latched | output | 1 | End-of-message latch state |
| eom_pulse | output | 1 | One-cycle pulse when the latch sets on a close |

## Verification
The bench builds the block with FLAGS_AFTER_ABORT set to 2 rather than the default 1. This exercises the flag countdown beyond its first step, so an off-by-one in the count shows up as a missing or extra flag. Directed phases stall `close_ready` inside the abort and flag sequence and issue a channel reset while an item is pending. A long random phase then mixes commands, mode changes and underruns against the reference model.

// File: rtl/tx_eom_pkg.sv
package tx_eom_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE  = 2'd0,
    KIND_CRC   = 2'd1,
    KIND_ABORT = 2'd2,
    KIND_FLAG  = 2'd3
  } close_kind_e;

  localparam logic [1:0] OP_NULL       = 2'b00;
  localparam logic [1:0] OP_RX_CHK_RST = 2'b01;
  localparam logic [1:0] OP_TX_GEN_RST = 2'b10;
  localparam logic [1:0] OP_EOM_CLR    = 2'b11;

  typedef struct packed {
    logic rx_rst;
    logic tx_rst;
    logic eom_clr;
  } op_req_t;

endpackage

// File: rtl/tx_eom_cmd_decode.sv
module tx_eom_cmd_decode
  import tx_eom_pkg::*;
(
  input  logic       op_wr,
  input  logic [1:0] op_code,
  input  logic       tx_en,
  output op_req_t    req
);

  always_comb begin
    req = '0;
    if (op_wr) begin
      unique case (op_code)
        OP_NULL:       ;
        OP_RX_CHK_RST: req.rx_rst  = 1'b1;
        OP_TX_GEN_RST: req.tx_rst  = tx_en;
        OP_EOM_CLR:    req.eom_clr = 1'b1;
        default:       ;
      endcase
    end
  end

endmodule

// File: rtl/tx_eom_rx_init.sv
module tx_eom_rx_init (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_rst_req,
  input  logic rx_en,
  input  logic sdlc,
  input  logic frame_end,
  output logic rx_init
);

  logic rx_en_q;
  logic rx_off_edge;

  assign rx_off_edge = rx_en_q & ~rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      rx_init <= 1'b0;
    end else begin
      rx_en_q <= rx_en;
      rx_init <= rx_rst_req | rx_off_edge | (sdlc & frame_end);
    end
  end

endmodule

// File: rtl/tx_eom_latch.sv
module tx_eom_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_reset,
  input  logic eom_clr,
  input  logic close_done,
  input  logic tx_rst_req,
  input  logic auto_mode,
  input  logic data_load,
  input  logic tx_en,
  output logic latched,
  output logic set_pulse,
  output logic tx_init
);

  logic armed;
  logic auto_fire;

  assign auto_fire = auto_mode & armed & data_load & tx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched   <= 1'b1;
      set_pulse <= 1'b0;
      tx_init   <= 1'b0;
      armed     <= 1'b1;
    end else begin
      tx_init   <= tx_rst_req | auto_fire;
      set_pulse <= close_done & ~latched & ~chan_reset;
      if (chan_reset)      latched <= 1'b1;
      else if (close_done) latched <= 1'b1;
      else if (eom_clr)    latched <= 1'b0;
      if (close_done)      armed <= 1'b1;
      else if (auto_fire)  armed <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_eom_close_seq.sv
module tx_eom_close_seq
  import tx_eom_pkg::*;
#(
  parameter int FLAGS_AFTER_ABORT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chan_reset,
  input  logic        underrun,
  input  logic        tx_en,
  input  logic        sdlc,
  input  logic        abort_opt,
  input  logic        eom_latched,
  input  logic        ready,
  output logic        valid,
  output close_kind_e kind,
  output logic        close_done
);

  localparam int CNT_W = (FLAGS_AFTER_ABORT < 2) ? 1 : $clog2(FLAGS_AFTER_ABORT + 1);

  logic [CNT_W-1:0] flags_left;
  logic             closing;
  logic             hs;
  logic             last;
  logic             start;

  assign hs    = valid & ready;
  assign last  = (kind == KIND_FLAG)  ? (flags_left == CNT_W'(1)) :
                 (kind != KIND_ABORT);
  assign start = ~valid & underrun & tx_en & ~chan_reset;
  assign close_done = hs & last & closing & ~chan_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      kind       <= KIND_IDLE;
      flags_left <= '0;
      closing    <= 1'b0;
    end else if (chan_reset) begin
      valid   <= 1'b0;
      closing <= 1'b0;
    end else if (hs) begin
      if (last) begin
        valid   <= 1'b0;
        closing <= 1'b0;
      end else if (kind == KIND_ABORT) begin
        kind       <= KIND_FLAG;
        flags_left <= CNT_W'(FLAGS_AFTER_ABORT);
      end else begin
        flags_left <= flags_left - CNT_W'(1);
      end
    end else if (start) begin
      valid <= 1'b1;
      if (eom_latched) begin
        kind    <= KIND_IDLE;
        closing <= 1'b0;
      end else if (sdlc && abort_opt) begin
        kind    <= KIND_ABORT;
        closing <= 1'b1;
      end else begin
        kind    <= KIND_CRC;
        closing <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tx_eom_ctrl.sv
module tx_eom_ctrl
  import tx_eom_pkg::*;
#(
  parameter int FLAGS_AFTER_ABORT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_code,
  input  logic       chan_reset,
  input  logic       tx_enable,
  input  logic       rx_enable,
  input  logic       sdlc_mode,
  input  logic       abort_on_underrun,
  input  logic       auto_eom_reset,
  input  logic       data_load,
  input  logic       rx_frame_end,
  input  logic       underrun,
  input  logic       close_ready,
  output logic       close_valid,
  output logic [1:0] close_kind,
  output logic       tx_crc_init,
  output logic       rx_crc_init,
  output logic       eom_latched,
  output logic       eom_pulse
);

  op_req_t     req;
  close_kind_e kind_w;
  logic        close_done;

  tx_eom_cmd_decode u_dec (
    .op_wr   (cmd_wr),
    .op_code (cmd_code),
    .tx_en   (tx_enable),
    .req     (req)
  );

  tx_eom_rx_init u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_rst_req (req.rx_rst),
    .rx_en      (rx_enable),
    .sdlc       (sdlc_mode),
    .frame_end  (rx_frame_end),
    .rx_init    (rx_crc_init)
  );

  tx_eom_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_reset (chan_reset),
    .eom_clr    (req.eom_clr),
    .close_done (close_done),
    .tx_rst_req (req.tx_rst),
    .auto_mode  (auto_eom_reset),
    .data_load  (data_load),
    .tx_en      (tx_enable),
    .latched    (eom_latched),
    .set_pulse  (eom_pulse),
    .tx_init    (tx_crc_init)
  );

  tx_eom_close_seq #(.FLAGS_AFTER_ABORT(FLAGS_AFTER_ABORT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_reset  (chan_reset),
    .underrun    (underrun),
    .tx_en       (tx_enable),
    .sdlc        (sdlc_mode),
    .abort_opt   (abort_on_underrun),
    .eom_latched (eom_latched),
    .ready       (close_ready),
    .valid       (close_valid),
    .kind        (kind_w),
    .close_done  (close_done)
  );

  assign close_kind = kind_w;

endmodule

// File: rtl/tx_eom_ctrl_checks.sv
module tx_eom_ctrl_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       chan_reset,
  input logic       tx_enable,
  input logic       underrun,
  input logic       close_ready,
  input logic       close_valid,
  input logic [1:0] close_kind,
  input logic       tx_crc_init,
  input logic       eom_latched,
  input logic       eom_pulse
);

  assert_item_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid && !close_ready && !chan_reset |=> close_valid && $stable(close_kind));

  assert_flag_after_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid && close_ready && close_kind == 2'd2 && !chan_reset |=> close_valid && close_kind == 2'd3);

  assert_pulse_on_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eom_pulse |-> eom_latched && !$past(eom_latched));

  assert_tx_init_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_crc_init |-> $past(tx_enable));

  assert_chan_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_reset |=> eom_latched && !close_valid && !eom_pulse);

  assert_underrun_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && tx_enable && !close_valid && !chan_reset |=> close_valid);

endmodule

bind tx_eom_ctrl tx_eom_ctrl_checks u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_reset  (chan_reset),
  .tx_enable   (tx_enable),
  .underrun    (underrun),
  .close_ready (close_ready),
  .close_valid (close_valid),
  .close_kind  (close_kind),
  .tx_crc_init (tx_crc_init),
  .eom_latched (eom_latched),
  .eom_pulse   (eom_pulse)
);

// File: tb/tx_eom_ctrl_test.sv
module tx_eom_ctrl_test;

  localparam int FLAGS = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_wr = 0, chan_reset = 0, tx_enable = 0, rx_enable = 0;
  logic sdlc_mode = 0, abort_on_underrun = 0, auto_eom_reset = 0;
  logic data_load = 0, rx_frame_end = 0, underrun = 0, close_ready = 1;
  logic [1:0] cmd_code = 2'b00;
  logic close_valid, tx_crc_init, rx_crc_init, eom_latched, eom_pulse;
  logic [1:0] close_kind;

  tx_eom_ctrl #(.FLAGS_AFTER_ABORT(FLAGS)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .chan_reset(chan_reset), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .sdlc_mode(sdlc_mode), .abort_on_underrun(abort_on_underrun),
    .auto_eom_reset(auto_eom_reset), .data_load(data_load),
    .rx_frame_end(rx_frame_end), .underrun(underrun), .close_ready(close_ready),
    .close_valid(close_valid), .close_kind(close_kind), .tx_crc_init(tx_crc_init),
    .rx_crc_init(rx_crc_init), .eom_latched(eom_latched), .eom_pulse(eom_pulse)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string phase = "R12";

  // behavioural reference state
  bit m_latch = 1, m_pulse = 0, m_txi = 0, m_rxi = 0, m_valid = 0;
  bit m_closing = 0, m_armed = 1, m_rxq = 0;
  int m_kind = 0;
  int mq[$];

  task automatic check(string tag, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s (phase %s) %s: actual=%0d expected=%0d", tag, phase, name, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    bit hs, close_done, fire, start;
    if (!rst_n) begin
      m_latch = 1; m_pulse = 0; m_txi = 0; m_rxi = 0; m_valid = 0;
      m_closing = 0; m_armed = 1; m_rxq = 0; m_kind = 0; mq.delete();
    end else begin
      hs = m_valid && close_ready;
      close_done = hs && mq.size() == 0 && m_closing && !chan_reset;
      fire = auto_eom_reset && m_armed && data_load && tx_enable;
      start = !m_valid && underrun && tx_enable && !chan_reset;
      m_txi = (cmd_wr && cmd_code == 2'b10 && tx_enable) || fire;
      m_rxi = (cmd_wr && cmd_code == 2'b01) || (m_rxq && !rx_enable) || (sdlc_mode && rx_frame_end);
      m_rxq = rx_enable;
      m_pulse = close_done && !m_latch;
      if (close_done) m_armed = 1; else if (fire) m_armed = 0;
      if (chan_reset) begin
        m_valid = 0; m_closing = 0; mq.delete();
      end else if (hs) begin
        if (mq.size() == 0) begin m_valid = 0; m_closing = 0; end
        else m_kind = mq.pop_front();
      end else if (start) begin
        m_valid = 1;
        if (m_latch) begin m_kind = 0; m_closing = 0; end
        else if (sdlc_mode && abort_on_underrun) begin
          m_kind = 2; m_closing = 1;
          for (int i = 0; i < FLAGS; i++) mq.push_back(3);
        end else begin m_kind = 1; m_closing = 1; end
      end
      if (chan_reset || close_done) m_latch = 1;
      else if (cmd_wr && cmd_code == 2'b11) m_latch = 0;
    end
    #3;
    check("R3 R11", "tx_crc_init", tx_crc_init, m_txi);
    check("R2", "rx_crc_init", rx_crc_init, m_rxi);
    check("R4 R7 R10", "eom_latched", eom_latched, m_latch);
    check("R7", "eom_pulse", eom_pulse, m_pulse);
    check("R9", "close_valid", close_valid, m_valid);
    if (m_valid) check("R5 R6 R8", "close_kind", close_kind, m_kind);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(logic [1:0] code);
    @(negedge clk); cmd_wr = 1; cmd_code = code;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic strobe_underrun();
    @(negedge clk); underrun = 1;
    @(negedge clk); underrun = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    phase = "R1"; tx_enable = 1; cmd(2'b00); tick(3);
    phase = "R3"; cmd(2'b10); tick(2);
    tx_enable = 0; cmd(2'b10); tick(2); tx_enable = 1;
    phase = "R2"; rx_enable = 1; tick(2); cmd(2'b01); tick(1);
    rx_enable = 0; tick(2);
    sdlc_mode = 1; rx_frame_end = 1; tick(1); rx_frame_end = 0; sdlc_mode = 0; tick(2);
    phase = "R4"; cmd(2'b11); tick(2);
    phase = "R5"; close_ready = 0; strobe_underrun(); tick(2);
    strobe_underrun(); tick(1); close_ready = 1; tick(3);
    phase = "R8"; strobe_underrun(); tick(3);
    phase = "R6"; cmd(2'b11); sdlc_mode = 1; abort_on_underrun = 1;
    strobe_underrun();
    for (int i = 0; i < 10; i++) begin close_ready = i[0]; tick(1); end
    close_ready = 1; tick(3);
    phase = "R9"; tx_enable = 0; cmd(2'b11); strobe_underrun(); tick(3); tx_enable = 1;
    phase = "R10"; close_ready = 0; strobe_underrun(); tick(1);
    chan_reset = 1; tick(1); chan_reset = 0; close_ready = 1; tick(3);
    phase = "R11"; auto_eom_reset = 1; sdlc_mode = 0; cmd(2'b11); strobe_underrun(); tick(3);
    data_load = 1; tick(1); data_load = 0; tick(1);
    data_load = 1; tick(1); data_load = 0; tick(3);
    phase = "random";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cmd_wr = ($urandom_range(0, 5) == 0);
      cmd_code = 2'($urandom_range(0, 3));
      chan_reset = ($urandom_range(0, 60) == 0);
      tx_enable = ($urandom_range(0, 9) != 0);
      rx_enable = ($urandom_range(0, 7) != 0);
      sdlc_mode = ($urandom_range(0, 2) != 0);
      abort_on_underrun = ($urandom_range(0, 1) != 0);
      auto_eom_reset = ($urandom_range(0, 1) != 0);
      data_load = ($urandom_range(0, 3) == 0);
      rx_frame_end = ($urandom_range(0, 9) == 0);
      underrun = ($urandom_range(0, 4) == 0);
      close_ready = ($urandom_range(0, 2) != 0);
    end
    @(negedge clk);
    cmd_wr = 0; chan_reset = 0; underrun = 0; data_load = 0; rx_frame_end = 0;
    tick(4);
    summary();
  end

endmodule